// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck, usually with SDA held low in the middle of a byte. On a trigger it first looks at the bus: the bus counts as available only when the controller's busy flag is clear and both SCL and SDA read high. If the bus is already available, nothing is driven and a pass result is returned at once. If it is not, the sequencer takes the two pin outputs away from the normal controller and plays a fixed pattern on them. The pattern is both lines high, a start condition, nine SCL clocks with SDA released, and then a stop condition. Every level is held for one programmable step interval.

When the pattern ends, pin control goes back to the controller and a one-cycle reset pulse is sent to it. In the cycle after that pulse the lines and the busy flag are checked again. One cycle later a done pulse comes out with a pass or fail flag. A fail result means the caller must refuse the pending transaction. The pin outputs use open-drain meaning: 1 releases the line and 0 pulls it low.

Top module: `rcv_bus_recovery`

## Requirements
- R1: After reset, pins_owned_o, ctrl_rst_o, done_o and pass_o are 0, and scl_o and sda_o follow the controller inputs.
- R2: bus_idle_o is 1 exactly when busy_i is 0 and scl_i and sda_i are both 1.
- R3: A trigger (start_i high for one sampling edge) while the bus is available never asserts pins_owned_o. done_o pulses in the next cycle with pass_o = 1.
- R4: A trigger while the bus is not available asserts pins_owned_o from the next cycle. The block then drives these (scl_o, sda_o) levels in order: (1,1), (1,0), (0,0), then (1,1),(0,1) repeated for each pulse, then (0,0), (1,0), (1,1).
- R5: Each level of the R4 pattern is held for exactly STEP_CYCLES clock cycles, so the whole override lasts (6 + 2*NUM_PULSES)*STEP_CYCLES cycles.
- R6: The pattern contains exactly NUM_PULSES SCL high/low pulses (default nine).
- R7: While pins_owned_o is 1, the controller inputs ctrl_scl_i and ctrl_sda_i have no effect on scl_o and sda_o. While it is 0, scl_o and sda_o equal them.
- R8: In the first cycle after pins_owned_o falls, ctrl_rst_o is 1 for exactly one cycle.
- R9: In the cycle after the ctrl_rst_o cycle, the bus availability (as in R2) is checked. done_o pulses for one cycle in the next cycle, with pass_o equal to that result. pass_o then holds until the next result.
- R10: start_i has no effect while a recovery sequence is running.
- R11: If the bus is still not available at the check after recovery, pass_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery trigger, sampled on the rising edge |
| busy_i | input | 1 | Busy flag from the normal controller |
| scl_i | input | 1 | SCL line level as read back |
| sda_i | input | 1 | SDA line level as read back |
| ctrl_scl_i | input | 1 | SCL output requested by the controller (1 = release) |
| ctrl_sda_i | input | 1 | SDA output requested by the controller (1 = release) |
| scl_o | output | 1 | SCL output to the pad (1 = release) |
| sda_o | output | 1 | SDA output to the pad (1 = release) |
| pins_owned_o | output | 1 | High while the sequencer overrides the pins |
| ctrl_rst_o | output | 1 | One-cycle reset pulse to the controller |
| bus_idle_o | output | 1 | Live bus availability |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Result of the last check, held |

## Verification
The scoreboard follows every level the override drives and the length of each level. A design that miscounted the pulses, ended a step one cycle early or late, or swapped the two stop edges would show up as a level or length mismatch or a leftover queue entry. The controller pulls both lines low and start_i is pulsed again in the middle of the pattern: a mux that leaked the controller through, or a sequencer that restarted, would break the recorded pattern. A bus that is already idle must produce a result with no override at all. A stuck SDA that stays low must produce a fail, and a busy flag that only the controller reset clears must produce a pass, which catches a check sampled before the reset pulse.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [3:0] {
    PH_IDLE      = 4'd0,
    PH_BOTH_HI   = 4'd1,
    PH_START_SDA = 4'd2,
    PH_START_SCL = 4'd3,
    PH_CLK_HI    = 4'd4,
    PH_CLK_LO    = 4'd5,
    PH_STOP_SDA  = 4'd6,
    PH_STOP_SCL  = 4'd7,
    PH_STOP_END  = 4'd8,
    PH_CTRL_RST  = 4'd9,
    PH_CHECK     = 4'd10
  } rcv_phase_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } rcv_lines_t;

  // Line levels forced during each override phase
  function automatic rcv_lines_t rcv_phase_lines(rcv_phase_e ph);
    rcv_lines_t lv;
    unique case (ph)
      PH_BOTH_HI:   lv = '{scl: 1'b1, sda: 1'b1};
      PH_START_SDA: lv = '{scl: 1'b1, sda: 1'b0};
      PH_START_SCL: lv = '{scl: 1'b0, sda: 1'b0};
      PH_CLK_HI:    lv = '{scl: 1'b1, sda: 1'b1};
      PH_CLK_LO:    lv = '{scl: 1'b0, sda: 1'b1};
      PH_STOP_SDA:  lv = '{scl: 1'b0, sda: 1'b0};
      PH_STOP_SCL:  lv = '{scl: 1'b1, sda: 1'b0};
      PH_STOP_END:  lv = '{scl: 1'b1, sda: 1'b1};
      default:      lv = '{scl: 1'b1, sda: 1'b1};
    endcase
    return lv;
  endfunction

  function automatic logic rcv_phase_owned(rcv_phase_e ph);
    return (ph >= PH_BOTH_HI) && (ph <= PH_STOP_END);
  endfunction

endpackage

// File: rtl/rcv_step_timer.sv
module rcv_step_timer #(
  parameter int STEP_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic step_done_o
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en      = 1'b0;
    cnt_d       = cnt_q;
    step_done_o = run_i && (cnt_q == LAST);
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = step_done_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: counter never exceeds one step
  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: an idle timer restarts from zero
  p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/rcv_seq_fsm.sv
module rcv_seq_fsm
  import rcv_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bus_avail_i,
  input  logic       step_done_i,
  output rcv_phase_e phase_o,
  output logic       own_o,
  output logic       ctrl_rst_o,
  output logic       done_o,
  output logic       pass_o
);
  localparam int PCW = $clog2(NUM_PULSES + 1);
  localparam logic [PCW-1:0] LAST_PULSE = PCW'(NUM_PULSES - 1);

  rcv_phase_e     phase_q, phase_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           done_q, done_d;
  logic           pass_q, pass_d;
  logic           pass_en;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (bus_avail_i) begin
            done_d = 1'b1;
            pass_d = 1'b1;
          end else begin
            phase_d = PH_BOTH_HI;
            pcnt_d  = '0;
          end
        end
      end
      PH_BOTH_HI:   if (step_done_i) phase_d = PH_START_SDA;
      PH_START_SDA: if (step_done_i) phase_d = PH_START_SCL;
      PH_START_SCL: if (step_done_i) phase_d = PH_CLK_HI;
      PH_CLK_HI:    if (step_done_i) phase_d = PH_CLK_LO;
      PH_CLK_LO: begin
        if (step_done_i) begin
          if (pcnt_q == LAST_PULSE) begin
            phase_d = PH_STOP_SDA;
            pcnt_d  = '0;
          end else begin
            phase_d = PH_CLK_HI;
            pcnt_d  = pcnt_q + 1'b1;
          end
        end
      end
      PH_STOP_SDA:  if (step_done_i) phase_d = PH_STOP_SCL;
      PH_STOP_SCL:  if (step_done_i) phase_d = PH_STOP_END;
      PH_STOP_END:  if (step_done_i) phase_d = PH_CTRL_RST;
      PH_CTRL_RST:  phase_d = PH_CHECK;
      PH_CHECK: begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
        pass_d  = bus_avail_i;
      end
      default:      phase_d = PH_IDLE;
    endcase
    pass_en = done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      done_q  <= done_d;
      if (pass_en) pass_q <= pass_d;
    end
  end

  assign phase_o    = phase_q;
  assign own_o      = rcv_phase_owned(phase_q);
  assign ctrl_rst_o = (phase_q == PH_CTRL_RST);
  assign done_o     = done_q;
  assign pass_o     = pass_q;

  // R6: pulse index stays within the configured pulse count
  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST_PULSE);

  // R10: a running sequence is not restarted by a new trigger
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START_SDA) && !step_done_i |=> phase_q == PH_START_SDA);

endmodule

// File: rtl/rcv_idle_check.sv
module rcv_idle_check (
  input  logic busy_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic avail_o
);
  assign avail_o = !busy_i && scl_i && sda_i;
endmodule

// File: rtl/rcv_pin_mux.sv
module rcv_pin_mux
  import rcv_pkg::*;
(
  input  rcv_phase_e phase_i,
  input  logic       own_i,
  input  logic       ctrl_scl_i,
  input  logic       ctrl_sda_i,
  output logic       scl_o,
  output logic       sda_o
);
  rcv_lines_t forced;

  always_comb begin
    forced = rcv_phase_lines(phase_i);
    if (own_i) begin
      scl_o = forced.scl;
      sda_o = forced.sda;
    end else begin
      scl_o = ctrl_scl_i;
      sda_o = ctrl_sda_i;
    end
  end
endmodule

// File: rtl/rcv_bus_recovery.sv
module rcv_bus_recovery
  import rcv_pkg::*;
#(
  parameter int STEP_CYCLES = 100000,
  parameter int NUM_PULSES  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ctrl_scl_i,
  input  logic ctrl_sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic pins_owned_o,
  output logic ctrl_rst_o,
  output logic bus_idle_o,
  output logic done_o,
  output logic pass_o
);
  rcv_phase_e phase;
  logic       own;
  logic       step_done;
  logic       avail;

  rcv_idle_check u_idle (
    .busy_i  (busy_i),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .avail_o (avail)
  );

  rcv_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (own),
    .step_done_o (step_done)
  );

  rcv_seq_fsm #(.NUM_PULSES(NUM_PULSES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bus_avail_i (avail),
    .step_done_i (step_done),
    .phase_o     (phase),
    .own_o       (own),
    .ctrl_rst_o  (ctrl_rst_o),
    .done_o      (done_o),
    .pass_o      (pass_o)
  );

  rcv_pin_mux u_mux (
    .phase_i    (phase),
    .own_i      (own),
    .ctrl_scl_i (ctrl_scl_i),
    .ctrl_sda_i (ctrl_sda_i),
    .scl_o      (scl_o),
    .sda_o      (sda_o)
  );

  assign pins_owned_o = own;
  assign bus_idle_o   = avail;

  // R8: controller reset lasts a single cycle
  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |=> !ctrl_rst_o);

  // R8: controller reset comes right after pins are handed back
  p_rst_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |-> !pins_owned_o && $past(pins_owned_o));

  // R9: done is a single-cycle strobe
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: result flag only moves together with done
  p_pass_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_o) |-> done_o);

  // R9: no result while the pins are still overridden
  p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pins_owned_o);

endmodule

// File: tb/sim_rcv_bus_recovery.sv
module sim_rcv_bus_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;
  localparam int NP   = 9;
  localparam int NPH  = 6 + 2 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, busy_i = 1'b0;
  logic ctrl_scl_i = 1'b1, ctrl_sda_i = 1'b1;
  logic hold_scl = 1'b0, hold_sda = 1'b0;
  logic scl_i, sda_i;
  logic scl_o, sda_o, pins_owned_o, ctrl_rst_o, bus_idle_o, done_o, pass_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: a stuck target can hold a line low
  assign scl_i = scl_o & ~hold_scl;
  assign sda_i = sda_o & ~hold_sda;

  rcv_bus_recovery #(.STEP_CYCLES(STEP), .NUM_PULSES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .scl_i(scl_i), .sda_i(sda_i), .ctrl_scl_i(ctrl_scl_i), .ctrl_sda_i(ctrl_sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .pins_owned_o(pins_owned_o),
    .ctrl_rst_o(ctrl_rst_o), .bus_idle_o(bus_idle_o), .done_o(done_o), .pass_o(pass_o)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {logic scl; logic sda;} exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_pattern();
    exp_q.push_back('{1'b1, 1'b1});
    exp_q.push_back('{1'b1, 1'b0});
    exp_q.push_back('{1'b0, 1'b0});
    for (int i = 0; i < NP; i++) begin
      exp_q.push_back('{1'b1, 1'b1});
      exp_q.push_back('{1'b0, 1'b1});
    end
    exp_q.push_back('{1'b0, 1'b0});
    exp_q.push_back('{1'b1, 1'b0});
    exp_q.push_back('{1'b1, 1'b1});
  endtask

  // monitor: run-length of each driven level while the pins are overridden
  logic [1:0] prev_lv = 2'b00;
  int run_len = 0;

  task automatic close_run();
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4 unexpected extra level", int'(prev_lv), 0);
    end else begin
      e = exp_q.pop_front();
      chk(prev_lv == {e.scl, e.sda}, "R4 level order", int'(prev_lv), int'({e.scl, e.sda}));
      chk(run_len == STEP, "R5 level duration", run_len, STEP);
    end
    run_len = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pins_owned_o) begin
        if (run_len > 0 && {scl_o, sda_o} != prev_lv) close_run();
        prev_lv = {scl_o, sda_o};
        run_len++;
      end else if (run_len > 0) begin
        close_run();
      end
    end
  end

  task automatic run_recovery(input bit keep_stuck, input bit exp_pass, input string tag);
    int cyc;
    @(negedge clk);
    #1 start_i = 1'b1;
    push_pattern();
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(pins_owned_o == 1'b1, {"R4 override starts ", tag}, pins_owned_o, 1);
      #1;
      if (cyc == 1) start_i = 1'b0;
      if (cyc == 5) start_i = 1'b1;         // R10: retrigger mid-sequence
      if (cyc == 6) start_i = 1'b0;
      if (cyc == 3) begin                    // R7: controller pulls low
        ctrl_scl_i = 1'b0;
        ctrl_sda_i = 1'b0;
      end
      if (cyc == 40) ctrl_sda_i = 1'b1;
    end while (!ctrl_rst_o && cyc < 4 * NPH * STEP);
    chk(cyc == NPH * STEP + 1, {"R5 total override length ", tag}, cyc, NPH * STEP + 1);
    chk(!pins_owned_o, {"R8 pins returned at reset ", tag}, pins_owned_o, 0);
    #1;
    busy_i = 1'b0;                           // controller reset clears busy
    ctrl_scl_i = 1'b1;
    ctrl_sda_i = 1'b1;
    if (!keep_stuck) begin
      hold_scl = 1'b0;
      hold_sda = 1'b0;
    end
    @(negedge clk);
    chk(ctrl_rst_o == 1'b0, {"R8 reset single cycle ", tag}, ctrl_rst_o, 0);
    chk(done_o == 1'b0, {"R9 done not yet ", tag}, done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, {"R9 done strobe ", tag}, done_o, 1);
    chk(pass_o == exp_pass, {"R9 R11 result ", tag}, pass_o, exp_pass);
    chk(exp_q.size() == 0, {"R6 pulse count drained ", tag}, exp_q.size(), 0);
    @(negedge clk);
    chk(done_o == 1'b0, {"R9 done single cycle ", tag}, done_o, 0);
    repeat (3) @(negedge clk);
    chk(pass_o == exp_pass, {"R9 result held ", tag}, pass_o, exp_pass);
    chk(!pins_owned_o, {"R10 no restart ", tag}, pins_owned_o, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!pins_owned_o && !ctrl_rst_o && !done_o && !pass_o, "R1 reset outputs",
        int'({pins_owned_o, ctrl_rst_o, done_o, pass_o}), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({scl_o, sda_o} == 2'b11, "R1 outputs follow controller", int'({scl_o, sda_o}), 3);

    // R2 availability combinations
    for (int k = 0; k < 8; k++) begin
      #1;
      busy_i   = k[0];
      hold_scl = k[1];
      hold_sda = k[2];
      @(negedge clk);
      chk(bus_idle_o == (k == 0), "R2 bus availability", bus_idle_o, int'(k == 0));
    end
    #1 busy_i = 1'b0; hold_scl = 1'b0; hold_sda = 1'b0;

    // R7 pass-through while not overridden
    for (int k = 0; k < 4; k++) begin
      #1 ctrl_scl_i = k[1]; ctrl_sda_i = k[0];
      @(negedge clk);
      chk({scl_o, sda_o} == k[1:0], "R7 pass-through", int'({scl_o, sda_o}), k);
    end
    #1 ctrl_scl_i = 1'b1; ctrl_sda_i = 1'b1;

    // R3 trigger on an idle bus
    @(negedge clk);
    #1 start_i = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b1, "R3 immediate done", done_o, 1);
    chk(pass_o == 1'b1, "R3 immediate pass", pass_o, 1);
    chk(!pins_owned_o, "R3 no override", pins_owned_o, 0);
    #1 start_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done single cycle", done_o, 0);
    chk(!pins_owned_o, "R3 still no override", pins_owned_o, 0);

    // stuck SDA released by the recovery
    #1 hold_sda = 1'b1;
    run_recovery(1'b0, 1'b1, "sda_freed");

    // R11 SDA stays stuck
    #1 hold_sda = 1'b1;
    run_recovery(1'b1, 1'b0, "sda_stuck");
    #1 hold_sda = 1'b0;

    // busy only, cleared by the controller reset
    #1 busy_i = 1'b1;
    run_recovery(1'b0, 1'b1, "busy_only");

    summary();
    $finish;
  end
endmodule